// File: doc/BRIEF.md
# Lane Data Block Distributor

This block sits on the transmit side of one lane of a die-to-die link. It takes a wide parallel word and spreads it over the lane's data IOs. The word is cut into fixed-size blocks. During one transfer window each IO gets exactly one block and sends it one bit per cycle, least significant bit first.

A matching collector on the receive side takes the per-IO serial bits and rebuilds the parallel word in the same block order. The block size is a configuration input with two choices: 8 bits, the default, or 10 bits for a high-bandwidth setting. The number of data IOs is a parameter.

The transmit side uses a valid/ready handshake on its input. It shows a transfer window by raising a bit-enable for exactly one block length. The receive side takes the same kind of bit-enable plus one bit per IO, and raises a one-cycle valid when a word is complete.

Top module: `lane_block_dist`

## Requirements
- R1: After reset, `tx_ready` is 1, `tx_bit_en` is 0, `tx_bits` is all zero and `rx_valid` is 0.
- R2: Block k of the word goes to IO k. Block k occupies word bits [k*B+B-1 : k*B], where B is the block size in force for that word.
- R3: Each IO sends its block least significant bit first. During the j-th enabled cycle of a window (j = 0 .. B-1), `tx_bits[k]` equals word bit k*B+j.
- R4: When `tx_cfg_wide` is 0 at acceptance, B is 8 and the window lasts 8 cycles. Word bits at and above NIO*8 are ignored.
- R5: When `tx_cfg_wide` is 1 at acceptance, B is 10 and the window lasts 10 cycles.
- R6: The transmit block size is sampled only in the cycle a word is accepted. A change to `tx_cfg_wide` during a window does not alter that window's length or bit mapping.
- R7: A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_bit_en` is 1 in the B cycles that follow. `tx_ready` is 0 during those cycles and returns to 1 right after them.
- R8: The collector raises `rx_valid` for exactly one cycle, in the cycle after the edge that samples the B-th enabled bit. `rx_word` then holds the rebuilt word in the R2 layout. In 8-bit mode every bit at and above NIO*8 is 0.
- R9: Whenever `tx_bit_en` is 0, every bit of `tx_bits` is 0.
- R10: The receive block size is sampled from `rx_cfg_wide` with the first enabled bit of a word. Changes to `rx_cfg_wide` later in the same word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_cfg_wide | input | 1 | Transmit block size: 0 = 8 bits, 1 = 10 bits |
| tx_valid | input | 1 | Parallel word is offered |
| tx_ready | output | 1 | Distributor can accept a word |
| tx_word | input | NIO*10 | Parallel word to distribute |
| tx_bit_en | output | 1 | Transfer window active; `tx_bits` carries data |
| tx_bits | output | NIO | One serial bit per data IO |
| rx_cfg_wide | input | 1 | Receive block size: 0 = 8 bits, 1 = 10 bits |
| rx_bit_en | input | 1 | Receive bits are valid this cycle |
| rx_bits | input | NIO | One serial bit per data IO |
| rx_valid | output | 1 | One-cycle pulse: `rx_word` is complete |
| rx_word | output | NIO*10 | Rebuilt parallel word |

## Verification
The assertions check the handshake on every cycle. They confirm that `tx_ready` is low inside a window, that an accepted word always opens a window, and that outputs are quiet outside a window. They also confirm that every window lasts exactly as long as the block size latched at acceptance, and that `rx_valid` never lasts more than one cycle. Only the bench scenarios can show that the data is right. They loop the transmit side into the collector and drive random words in both block sizes, plus directed patterns. They check each IO's bit order cycle by cycle, check that high word bits are dropped in 8-bit mode, and change the configuration inputs in the middle of a word.

// File: rtl/ldd_pkg.sv
package ldd_pkg;

    localparam int unsigned BLK_NARROW = 8;
    localparam int unsigned BLK_WIDE   = 10;
    localparam int unsigned BLK_MAX    = BLK_WIDE;
    localparam int unsigned CNT_W      = $clog2(BLK_MAX + 1);

    typedef enum logic {
        BLK8  = 1'b0,
        BLK10 = 1'b1
    } blk_mode_e;

    typedef struct packed {
        logic             busy;
        blk_mode_e        mode;
        logic [CNT_W-1:0] cnt;
    } seq_state_t;

    // Index of the final bit time for a block mode.
    function automatic logic [CNT_W-1:0] last_bit(blk_mode_e m);
        return (m == BLK10) ? CNT_W'(BLK_WIDE - 1) : CNT_W'(BLK_NARROW - 1);
    endfunction

endpackage

// File: rtl/ldd_tx_blk.sv
module ldd_tx_blk
    import ldd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  wide,
    input  logic [BLK_NARROW-1:0] narrow_val,
    input  logic [BLK_WIDE-1:0]   wide_val,
    input  logic                  shift,
    output logic                  lsb
);
    logic [BLK_MAX-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= wide ? wide_val : {{(BLK_MAX-BLK_NARROW){1'b0}}, narrow_val};
        end else if (shift) begin
            sh_q <= {1'b0, sh_q[BLK_MAX-1:1]};
        end
    end

    assign lsb = sh_q[0];
endmodule

// File: rtl/ldd_rx_blk.sv
module ldd_rx_blk
    import ldd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               shift,
    input  logic               bit_in,
    output logic [BLK_MAX-1:0] blk
);
    always_ff @(posedge clk) begin
        if (rst) begin
            blk <= '0;
        end else if (shift) begin
            blk <= {bit_in, blk[BLK_MAX-1:1]};
        end
    end
endmodule

// File: rtl/ldd_tx.sv
module ldd_tx
    import ldd_pkg::*;
#(
    parameter  int unsigned NIO    = 38,
    localparam int unsigned WORD_W = NIO * BLK_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wide,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              bit_en,
    output logic [NIO-1:0]    bits
);
    seq_state_t st_q;
    logic       accept;
    logic [NIO-1:0] lsb_w;

    assign accept = in_valid && !st_q.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (accept) begin
            st_q.busy <= 1'b1;
            st_q.mode <= blk_mode_e'(cfg_wide);
            st_q.cnt  <= '0;
        end else if (st_q.busy) begin
            if (st_q.cnt == last_bit(st_q.mode)) begin
                st_q.busy <= 1'b0;
            end
            st_q.cnt <= st_q.cnt + 1'b1;
        end
    end

    for (genvar k = 0; k < NIO; k++) begin : g_io
        ldd_tx_blk u_blk (
            .clk        (clk),
            .rst        (rst),
            .load       (accept),
            .wide       (cfg_wide),
            .narrow_val (in_word[k*BLK_NARROW +: BLK_NARROW]),
            .wide_val   (in_word[k*BLK_WIDE +: BLK_WIDE]),
            .shift      (st_q.busy),
            .lsb        (lsb_w[k])
        );
        assign bits[k] = lsb_w[k] & st_q.busy;
    end

    assign in_ready = !st_q.busy;
    assign bit_en   = st_q.busy;
endmodule

// File: rtl/ldd_rx.sv
module ldd_rx
    import ldd_pkg::*;
#(
    parameter  int unsigned NIO    = 38,
    localparam int unsigned WORD_W = NIO * BLK_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wide,
    input  logic              bit_en,
    input  logic [NIO-1:0]    bits,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);
    seq_state_t     st_q;
    blk_mode_e      eff_mode;
    logic           last;
    logic [BLK_MAX-1:0] blk_w [NIO];

    assign eff_mode = st_q.busy ? st_q.mode : blk_mode_e'(cfg_wide);
    assign last     = (st_q.cnt == last_bit(eff_mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (bit_en) begin
                st_q.mode <= eff_mode;
                if (last) begin
                    st_q.busy <= 1'b0;
                    st_q.cnt  <= '0;
                    out_valid <= 1'b1;
                end else begin
                    st_q.busy <= 1'b1;
                    st_q.cnt  <= st_q.cnt + 1'b1;
                end
            end
        end
    end

    for (genvar k = 0; k < NIO; k++) begin : g_io
        ldd_rx_blk u_blk (
            .clk    (clk),
            .rst    (rst),
            .shift  (bit_en),
            .bit_in (bits[k]),
            .blk    (blk_w[k])
        );
    end

    always_comb begin
        out_word = '0;
        for (int k = 0; k < NIO; k++) begin
            if (st_q.mode == BLK10) begin
                out_word[k*BLK_WIDE +: BLK_WIDE] = blk_w[k];
            end else begin
                out_word[k*BLK_NARROW +: BLK_NARROW] = blk_w[k][BLK_MAX-1 -: BLK_NARROW];
            end
        end
    end
endmodule

// File: rtl/lane_block_dist.sv
module lane_block_dist
    import ldd_pkg::*;
#(
    parameter  int unsigned NIO    = 38,
    localparam int unsigned WORD_W = NIO * BLK_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_cfg_wide,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_bit_en,
    output logic [NIO-1:0]    tx_bits,
    input  logic              rx_cfg_wide,
    input  logic              rx_bit_en,
    input  logic [NIO-1:0]    rx_bits,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_word
);
    ldd_tx #(.NIO(NIO)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .cfg_wide (tx_cfg_wide),
        .in_valid (tx_valid),
        .in_ready (tx_ready),
        .in_word  (tx_word),
        .bit_en   (tx_bit_en),
        .bits     (tx_bits)
    );

    ldd_rx #(.NIO(NIO)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .cfg_wide  (rx_cfg_wide),
        .bit_en    (rx_bit_en),
        .bits      (rx_bits),
        .out_valid (rx_valid),
        .out_word  (rx_word)
    );
endmodule

// File: rtl/lane_block_dist_chk.sv
module lane_block_dist_chk
    import ldd_pkg::*;
#(
    parameter int unsigned NIO = 38
) (
    input logic           clk,
    input logic           rst,
    input logic           tx_cfg_wide,
    input logic           tx_valid,
    input logic           tx_ready,
    input logic           tx_bit_en,
    input logic [NIO-1:0] tx_bits,
    input logic           rx_valid
);
    logic [CNT_W-1:0] run_q;
    logic             mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            run_q <= tx_bit_en ? run_q + 1'b1 : '0;
            if (tx_valid && tx_ready) begin
                mode_q <= tx_cfg_wide;
            end
        end
    end

    // R7: no acceptance possible inside a window
    a_r7_ready_low_in_window: assert property (@(posedge clk) disable iff (rst)
        tx_bit_en |-> !tx_ready);

    // R7: an accepted word opens a window on the next cycle
    a_r7_accept_opens_window: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> tx_bit_en);

    // R6: window length matches the size latched at acceptance
    a_r6_window_length: assert property (@(posedge clk) disable iff (rst)
        (!tx_bit_en && run_q != '0) |->
            (run_q == (mode_q ? CNT_W'(BLK_WIDE) : CNT_W'(BLK_NARROW))));

    // R9: serial outputs quiet outside a window
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !tx_bit_en |-> (tx_bits == '0));

    // R8: completion is a single-cycle pulse
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

bind lane_block_dist lane_block_dist_chk #(.NIO(NIO)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .tx_cfg_wide (tx_cfg_wide),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_bit_en   (tx_bit_en),
    .tx_bits     (tx_bits),
    .rx_valid    (rx_valid)
);

// File: tb/lane_block_dist_tb_top.sv
module lane_block_dist_tb_top;
    localparam int unsigned NIO    = 38;
    localparam int unsigned WORD_W = NIO * 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              tx_cfg_wide, tx_valid, tx_ready, tx_bit_en;
    logic [WORD_W-1:0] tx_word;
    logic [NIO-1:0]    tx_bits;
    logic              rx_cfg_wide, rx_valid;
    logic [WORD_W-1:0] rx_word;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lane_block_dist #(.NIO(NIO)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .tx_cfg_wide (tx_cfg_wide),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_word     (tx_word),
        .tx_bit_en   (tx_bit_en),
        .tx_bits     (tx_bits),
        .rx_cfg_wide (rx_cfg_wide),
        .rx_bit_en   (tx_bit_en),
        .rx_bits     (tx_bits),
        .rx_valid    (rx_valid),
        .rx_word     (rx_word)
    );

    function automatic logic [NIO-1:0] exp_bits(logic [WORD_W-1:0] w, int bsz, int j);
        logic [NIO-1:0] e;
        for (int k = 0; k < NIO; k++) e[k] = w[k*bsz + j];
        return e;
    endfunction

    function automatic logic [WORD_W-1:0] exp_word(logic [WORD_W-1:0] w, logic wide);
        logic [WORD_W-1:0] e = '0;
        for (int i = 0; i < NIO*8; i++) e[i] = w[i];
        return wide ? w : e;
    endfunction

    function automatic logic [WORD_W-1:0] rand_word();
        logic [WORD_W-1:0] w;
        for (int i = 0; i < WORD_W; i++) w[i] = 1'($urandom);
        return w;
    endfunction

    task automatic check(string req, logic ok, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R2 R3 R4 R5 R6 R7 R8 R10: send one word through loopback and check every bit time
    task automatic send(logic [WORD_W-1:0] w, logic wide, bit disturb);
        int bsz = wide ? 10 : 8;
        @(negedge clk);
        tx_valid = 1'b1; tx_word = w; tx_cfg_wide = wide; rx_cfg_wide = wide;
        @(negedge clk);
        tx_valid = 1'b0;
        if (disturb) begin tx_cfg_wide = ~wide; tx_word = ~w; end
        for (int j = 0; j < bsz; j++) begin
            if (j == 1 && disturb) rx_cfg_wide = ~wide;
            check("R7 window/ready", tx_bit_en && !tx_ready,
                  WORD_W'({tx_bit_en, tx_ready}), WORD_W'(2'b10));
            check(wide ? "R2 R3 R5 bits" : "R2 R3 R4 bits",
                  tx_bits == exp_bits(w, bsz, j),
                  WORD_W'(tx_bits), WORD_W'(exp_bits(w, bsz, j)));
            check("R8 no early valid", !rx_valid, WORD_W'(rx_valid), '0);
            @(negedge clk);
        end
        check("R6 R7 window closed", !tx_bit_en && tx_ready,
              WORD_W'({tx_bit_en, tx_ready}), WORD_W'(2'b01));
        check("R9 idle bits zero", tx_bits == '0, WORD_W'(tx_bits), '0);
        check("R8 R10 rx_valid", rx_valid, WORD_W'(rx_valid), WORD_W'(1));
        check("R8 R4 rx_word", rx_word == exp_word(w, wide), rx_word, exp_word(w, wide));
        @(negedge clk);
        check("R8 pulse ends", !rx_valid, WORD_W'(rx_valid), '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [WORD_W-1:0] w;
        void'($urandom(32'd20250819));
        rst = 1'b1; tx_valid = 1'b0; tx_word = '0; tx_cfg_wide = 1'b0; rx_cfg_wide = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 reset", tx_ready && !tx_bit_en && tx_bits == '0 && !rx_valid,
              WORD_W'({tx_ready, tx_bit_en, rx_valid}), WORD_W'(3'b100));
        // Directed corners
        send('1, 1'b0, 1'b0);
        send('1, 1'b1, 1'b0);
        w = '0;
        for (int k = 0; k < NIO; k++) w[k*8 + 7] = 1'b1;   // R3 top bit of each 8-bit block
        send(w, 1'b0, 1'b1);
        w = '0;
        for (int k = 0; k < NIO; k++) w[k*10 + 9] = 1'b1;  // R3 top bit of each 10-bit block
        send(w, 1'b1, 1'b1);
        w = '0;
        for (int k = 0; k < NIO; k++) w[k*8] = 1'b1;       // R3 first bit only
        send(w, 1'b0, 1'b0);
        // Random words, both sizes, with mid-word config changes (R6 R10)
        for (int n = 0; n < 60; n++) begin
            send(rand_word(), 1'($urandom), 1'($urandom));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule